// File: doc/BRIEF.md
# Infrared Carrier Modulator

This block produces a square-wave carrier near 38 kHz from the system clock and combines it with up to eight port output levels. It lets a serial transmit line or an LED driver feed an infrared emitter directly. A counter divides the clock to the carrier rate. The divider ratio follows from two parameters: the clock frequency and the carrier frequency.

Each output pin is the level software wrote to it, XOR'ed with the carrier. This happens only when two conditions hold: the global modulation enable is high, and that pin's bit in the select vector is set. Every other pin passes its level through unchanged. While modulation is off, the carrier counter is held cleared. As a result, every enable starts the carrier from the same phase.

Top module: `irmod_top`

## Requirements
- R1: While `modEnable` is low, `pinOut` equals `pinLevel` on every pin, whatever `pinSel` holds.
- R2: A pin whose `pinSel` bit is 0 outputs its `pinLevel` bit unchanged, even while modulation is enabled.
- R3: While `modEnable` is high, a pin whose `pinSel` bit is 1 outputs its level XOR the carrier. A level of 0 therefore shows the carrier, and a level of 1 shows the inverted carrier.
- R4: The carrier half period is HALF = round(CLK_HZ / (2 * CARRIER_HZ)) clock cycles. Every high phase and every low phase lasts exactly HALF cycles, which gives a 50 percent duty cycle.
- R5: The carrier starts low after enable. It first goes high on the HALF-th rising clock edge at which `modEnable` is sampled high.
- R6: Lowering `modEnable` returns all pins to pass-through in the same cycle, without waiting for a clock edge. The next enable restarts the carrier phase exactly as in R5.
- R7: During and after reset (`rstN` low, active low), the carrier is low and `pinOut` equals `pinLevel`.
- R8: Changing `pinSel` while modulation runs takes effect without a clock edge and does not disturb the carrier phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modEnable | input | 1 | Global modulation enable |
| pinSel | input | PIN_COUNT | Per-pin modulation select, 1 = modulate |
| pinLevel | input | PIN_COUNT | Unmodulated pin levels written by software |
| pinOut | output | PIN_COUNT | Final pin levels |

## Verification
The bench keeps its own carrier model, driven only by how many edges have passed since enable. It compares all pins against that model every cycle for four kinds of stimulus. Varied select and level patterns with the enable low show whether pass-through leaks any carrier. Level 0 and level 1 on selected pins show the XOR polarity, and unselected neighbours show whether the per-pin mask works. Measuring phase lengths under a clock ratio that does not divide evenly tells rounding apart from truncation. Re-enabling and changing the select mid-run show whether the phase restarts when it should and runs on undisturbed when it should.

// File: rtl/irmod_pkg.sv
package irmod_pkg;
  typedef struct packed {
    logic carrierRun;
    logic carrierToggle;
  } ctrlStrobes_t;

  function automatic int halfPeriod(input longint clkHz, input longint carrierHz);
    return int'((clkHz + carrierHz) / (2 * carrierHz));
  endfunction
endpackage

// File: rtl/irmod_ctrl.sv
module irmod_ctrl
  import irmod_pkg::*;
#(
  parameter int HALF = 158
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         modEnable,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] divCount;
  logic atLast;

  assign atLast = (divCount == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCount <= '0;
    end else if (!modEnable) begin
      divCount <= '0;
    end else if (atLast) begin
      divCount <= '0;
    end else begin
      divCount <= divCount + 1'b1;
    end
  end

  always_comb begin
    strobes.carrierRun    = modEnable;
    strobes.carrierToggle = modEnable && atLast;
  end

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    divCount <= LAST);

  assert_idle_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |=> divCount == '0);
endmodule

// File: rtl/irmod_dpath.sv
module irmod_dpath
  import irmod_pkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [PIN_COUNT-1:0] pinSel,
  input  logic [PIN_COUNT-1:0] pinLevel,
  output logic [PIN_COUNT-1:0] pinOut
);
  logic carrier;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carrier <= 1'b0;
    end else if (!strobes.carrierRun) begin
      carrier <= 1'b0;
    end else if (strobes.carrierToggle) begin
      carrier <= ~carrier;
    end
  end

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    always_comb begin
      pinOut[p] = pinLevel[p] ^ (strobes.carrierRun & pinSel[p] & carrier);
    end
  end

  assert_carrier_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.carrierRun |=> !carrier);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.carrierRun && strobes.carrierToggle) |=> carrier != $past(carrier));

  assert_hold_between_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.carrierRun && !strobes.carrierToggle) |=> $stable(carrier));
endmodule

// File: rtl/irmod_top.sv
module irmod_top
  import irmod_pkg::*;
#(
  parameter longint CLK_HZ     = 12_000_000,
  parameter longint CARRIER_HZ = 38_000,
  parameter int     PIN_COUNT  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modEnable,
  input  logic [PIN_COUNT-1:0] pinSel,
  input  logic [PIN_COUNT-1:0] pinLevel,
  output logic [PIN_COUNT-1:0] pinOut
);
  localparam int HALF = halfPeriod(CLK_HZ, CARRIER_HZ);

  ctrlStrobes_t strobes;

  irmod_ctrl #(.HALF(HALF)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .modEnable(modEnable),
    .strobes  (strobes)
  );

  irmod_dpath #(.PIN_COUNT(PIN_COUNT)) dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .pinSel  (pinSel),
    .pinLevel(pinLevel),
    .pinOut  (pinOut)
  );

  assert_passthru_R1: assert property (@(posedge clk) disable iff (!rstN)
    !modEnable |-> pinOut == pinLevel);

  assert_unselected_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinSel) == (pinLevel & ~pinSel));

  assert_common_carrier_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones((pinOut ^ pinLevel) & pinSel) == 0 ||
    ((pinOut ^ pinLevel) & pinSel) == pinSel);
endmodule

// File: tb/irmod_top_tb_top.sv
module irmod_top_tb_top;
  localparam int N = 8;
  // 800000 / 76000 = 10.53, rounds to 11 (truncation would give 10)
  localparam int EXP_HALF = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modEnable = 1'b0;
  logic [N-1:0] pinSel = '0;
  logic [N-1:0] pinLevel = '0;
  logic [N-1:0] pinOut;

  int total = 0;
  int bad = 0;
  int edgesOn = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irmod_top #(.CLK_HZ(800_000), .CARRIER_HZ(38_000), .PIN_COUNT(N)) dut_i (
    .clk(clk), .rstN(rstN), .modEnable(modEnable),
    .pinSel(pinSel), .pinLevel(pinLevel), .pinOut(pinOut)
  );

  function automatic logic modelCarrier();
    return modEnable ? logic'((edgesOn / EXP_HALF) % 2) : 1'b0;
  endfunction

  function automatic logic [N-1:0] expectOut();
    return pinLevel ^ (modEnable ? (pinSel & {N{modelCarrier()}}) : '0);
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: pinOut=%b expected=%b", req, act, exp);
    end
  endtask

  // one clock: inputs already set at negedge, advance model, sample at next negedge
  task automatic step(string req);
    @(posedge clk);
    if (modEnable) edgesOn++; else edgesOn = 0;
    @(negedge clk);
    check(req, pinOut, expectOut());
  endtask

  task automatic test_reset();
    pinLevel = 8'hA5; pinSel = 8'hFF; modEnable = 1'b1;
    repeat (3) @(negedge clk);
    check("R7", pinOut, 8'hA5);
    @(negedge clk);
    rstN = 1'b1; modEnable = 1'b0; edgesOn = 0;
    step("R7");
  endtask

  task automatic test_disabled();
    modEnable = 1'b0;
    for (int i = 0; i < 30; i++) begin
      pinSel = 8'(i * 37 + 5);
      pinLevel = 8'(i * 91 + 3);
      step("R1");
    end
  endtask

  task automatic test_timing();
    int runLen;
    logic prev;
    pinSel = 8'h01; pinLevel = 8'h00;
    modEnable = 1'b1; edgesOn = 0;
    runLen = 0;
    prev = pinOut[0];
    check("R5", {7'b0, prev}, 8'h00);
    while (pinOut[0] == prev && runLen < 100) begin
      @(posedge clk); edgesOn++; @(negedge clk); runLen++;
    end
    check("R5", 8'(runLen), 8'(EXP_HALF));
    for (int r = 0; r < 4; r++) begin
      prev = pinOut[0];
      runLen = 0;
      while (pinOut[0] == prev && runLen < 100) begin
        @(posedge clk); edgesOn++; @(negedge clk); runLen++;
      end
      check("R4", 8'(runLen), 8'(EXP_HALF));
    end
    modEnable = 1'b0;
    step("R6");
  endtask

  task automatic test_levels();
    modEnable = 1'b0; step("R3");
    pinSel = 8'hFF; pinLevel = 8'h0F; modEnable = 1'b1;
    for (int i = 0; i < 3 * EXP_HALF; i++) step("R3");
    pinLevel = 8'hF0;
    for (int i = 0; i < 2 * EXP_HALF; i++) step("R3");
  endtask

  task automatic test_unselected();
    pinSel = 8'h3C; pinLevel = 8'h00;
    for (int i = 0; i < 2 * EXP_HALF; i++) begin
      pinLevel = 8'(i * 29);
      step("R2");
    end
  endtask

  task automatic test_restart();
    pinSel = 8'hFF; pinLevel = 8'h00;
    for (int i = 0; i < EXP_HALF + 3; i++) step("R6");
    modEnable = 1'b0;
    #1 check("R6", pinOut, pinLevel);
    step("R6");
    modEnable = 1'b1;
    for (int i = 0; i < 2 * EXP_HALF + 2; i++) step("R6");
  endtask

  task automatic test_sel_change();
    for (int i = 0; i < 4 * EXP_HALF; i++) begin
      pinSel = 8'(1 << (i % N));
      pinLevel = 8'(i * 13);
      #1 check("R8", pinOut, expectOut());
      step("R8");
    end
    modEnable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_disabled();
    test_timing();
    test_levels();
    test_unselected();
    test_restart();
    test_sel_change();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule